// File: doc/BRIEF.md
# Timer Wakeup Request Generator

This block turns three timer events into one sticky wakeup request for a sleep controller. The events are a counter wrap from all-ones to zero, the counter equalling an alarm compare value, and a zero-to-one change of one chosen bit of a prescaler vector. Each event sets its own status bit. The wake request is raised while any status bit is set and the matching source is enabled.

Software drives a small write port. One address loads the per-source enable bits. The other address clears status bits: a one in the written data clears that bit, and a zero leaves it alone. A status bit stays set until it is cleared this way, so a sleep attempt made before clearing ends at once. The enable bits act only on the wake output. They never touch the status bits, and there is no interrupt mask in this path.

The asynchronous active-low reset is synchronised inside the block before it is released.

Top module: `tmr_wake_gen`

## Requirements
- R1: Status bit 0 (overflow) is set one clock after a cycle in which the counter value is zero and the counter value sampled on the previous clock was all ones.
- R2: Status bit 1 (alarm) is set one clock after any cycle in which the counter value equals the alarm value.
- R3: Status bit 2 (prescaler) is set one clock after a cycle in which the prescaler bit picked by the select input is one and the bit sampled on the previous clock was zero.
- R4: A set status bit stays set, with or without its enable bit, until software clears it.
- R5: A write to address 1 clears each status bit whose data bit is one, one clock after the write. A zero data bit has no effect. When an event and a clear of the same bit fall in one cycle, the bit ends up set.
- R6: A write to address 0 loads the enable bits (bit 0 overflow, bit 1 alarm, bit 2 prescaler). The wake output is the OR of the status bits that are set and enabled, and it reflects a write one clock after that write.
- R7: After reset, all status bits, all enable bits and the wake output are zero.
- R8: Changing the enable bits never changes the status bits. Enabling a source whose status bit is already set raises wake on the next clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_val | input | CNT_W | Current counter value |
| alarm_val | input | CNT_W | Alarm compare value |
| psc_vec | input | PSC_W | Prescaler stage vector |
| psc_sel | input | SEL_W | Index of the watched prescaler bit |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = wake enable, 1 = status clear |
| wr_data | input | 3 | Write data, one bit per source |
| wake_req | output | 1 | Wakeup request to the sleep controller |
| wake_status | output | 3 | Sticky per-source status |

## Verification
The bench targets a clear and a new event landing on the same bit in one cycle. A design that lets the clear win would drop a wakeup. It also writes zero to the clear address, which a design that loads the register instead of masking it would use to erase all pending status. The bench sets status while the source is disabled and enables it later; a design that gates status with the enable would never raise wake there. The bench also changes the select and holds the counter at all-ones and then at zero, which exposes edge and wrap detectors that compare against the wrong previous sample.

// File: rtl/tmr_wake_pkg.sv
package tmr_wake_pkg;
  localparam int NSRC    = 3;
  localparam int SRC_OVF = 0;
  localparam int SRC_ALM = 1;
  localparam int SRC_PSC = 2;
  localparam logic ADDR_EN  = 1'b0;
  localparam logic ADDR_CLR = 1'b1;
  typedef logic [NSRC-1:0] src_vec_t;
endpackage

// File: rtl/tmr_wake_cnt_ev.sv
module tmr_wake_cnt_ev #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic [CNT_W-1:0] alarm_val,
  output logic             ovf_ev,
  output logic             alm_ev
);
  logic [CNT_W-1:0] prev_q, prev_d;

  always_comb begin
    prev_d = cnt_val;
    ovf_ev = (&prev_q) && (cnt_val == '0);
    alm_ev = (cnt_val == alarm_val);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_d;
  end
endmodule

// File: rtl/tmr_wake_psc_edge.sv
module tmr_wake_psc_edge #(
  parameter int PSC_W = 16,
  localparam int SEL_W = (PSC_W > 1) ? $clog2(PSC_W) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PSC_W-1:0] psc_vec,
  input  logic [SEL_W-1:0] psc_sel,
  output logic             psc_ev
);
  logic bit_now, bit_q;

  always_comb begin
    bit_now = 1'b0;
    for (int i = 0; i < PSC_W; i++)
      if (psc_sel == SEL_W'(i)) bit_now = psc_vec[i];
    psc_ev = bit_now & ~bit_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bit_q <= 1'b0;
    else        bit_q <= bit_now;
  end
endmodule

// File: rtl/tmr_wake_regs.sv
module tmr_wake_regs
  import tmr_wake_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  src_vec_t ev,
  input  logic     wr_en,
  input  logic     wr_addr,
  input  src_vec_t wr_data,
  output src_vec_t status_q,
  output src_vec_t en_q
);
  src_vec_t status_d, en_d, clr_mask;
  logic     en_load, st_load;

  always_comb begin
    clr_mask = (wr_en && wr_addr == ADDR_CLR) ? wr_data : '0;
    en_load  = wr_en && (wr_addr == ADDR_EN);
    status_d = (status_q & ~clr_mask) | ev;
    st_load  = (status_d != status_q);
    en_d     = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       status_q <= '0;
    else if (st_load) status_q <= status_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       en_q <= '0;
    else if (en_load) en_q <= en_d;
  end
endmodule

// File: rtl/tmr_wake_gen.sv
module tmr_wake_gen
  import tmr_wake_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PSC_W = 16,
  localparam int SEL_W = (PSC_W > 1) ? $clog2(PSC_W) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic [CNT_W-1:0] alarm_val,
  input  logic [PSC_W-1:0] psc_vec,
  input  logic [SEL_W-1:0] psc_sel,
  input  logic             wr_en,
  input  logic             wr_addr,
  input  logic [2:0]       wr_data,
  output logic             wake_req,
  output logic [2:0]       wake_status
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       ovf_ev, alm_ev, psc_ev;
  src_vec_t   ev_all, status_q, en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  tmr_wake_cnt_ev #(.CNT_W(CNT_W)) u_cnt_ev (
    .clk(clk), .rst_n(rst_int_n), .cnt_val(cnt_val), .alarm_val(alarm_val),
    .ovf_ev(ovf_ev), .alm_ev(alm_ev)
  );

  tmr_wake_psc_edge #(.PSC_W(PSC_W)) u_psc_edge (
    .clk(clk), .rst_n(rst_int_n), .psc_vec(psc_vec), .psc_sel(psc_sel),
    .psc_ev(psc_ev)
  );

  always_comb begin
    ev_all          = '0;
    ev_all[SRC_OVF] = ovf_ev;
    ev_all[SRC_ALM] = alm_ev;
    ev_all[SRC_PSC] = psc_ev;
  end

  tmr_wake_regs u_regs (
    .clk(clk), .rst_n(rst_int_n), .ev(ev_all), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .status_q(status_q), .en_q(en_q)
  );

  assign wake_req    = |(status_q & en_q);
  assign wake_status = status_q;
endmodule

// File: rtl/tmr_wake_gen_chk.sv
module tmr_wake_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       wr_addr,
  input logic [2:0] wr_data,
  input logic [2:0] ev,
  input logic [2:0] status,
  input logic       wake
);
  logic [2:0] clr_m;
  assign clr_m = (wr_en && wr_addr) ? wr_data : 3'b000;

  // R1 R2 R3: a status bit only rises after its event
  p_rise_needs_event_r1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & ~$past(status) & ~$past(ev)) == 3'b000));

  // R4: set bits survive when not cleared
  p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & $past(status & ~clr_m)) == $past(status & ~clr_m)));

  // R5: cleared bits without a same-cycle event drop
  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_m != 3'b000) |=> ((status & $past(clr_m & ~ev)) == 3'b000));

  // R5: events win over a clear in the same cycle
  p_event_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev != 3'b000) |=> ((status & $past(ev)) == $past(ev)));

  // R6: wake needs some set status bit
  p_wake_needs_status_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> (status != 3'b000));

  // R4 R6: without writes wake does not drop
  p_wake_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wake && !wr_en) |=> wake);
endmodule

bind tmr_wake_gen tmr_wake_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .ev(ev_all), .status(wake_status), .wake(wake_req)
);

// File: tb/tmr_wake_gen_bench.sv
module tmr_wake_gen_bench;
  localparam int CNT_W = 32;
  localparam int PSC_W = 16;
  localparam int SEL_W = $clog2(PSC_W);

  logic             clk = 1'b0;
  logic             rst_n;
  logic [CNT_W-1:0] cnt_val, alarm_val;
  logic [PSC_W-1:0] psc_vec;
  logic [SEL_W-1:0] psc_sel;
  logic             wr_en, wr_addr;
  logic [2:0]       wr_data;
  logic             wake_req;
  logic [2:0]       wake_status;

  int checks = 0;
  int failures = 0;
  logic             done = 1'b0;

  logic [2:0]       m_st, m_en;
  logic [CNT_W-1:0] m_prev_cnt;
  logic             m_prev_bit;

  always #2 clk = ~clk;

  tmr_wake_gen #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_tmr_wake_gen (
    .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .alarm_val(alarm_val),
    .psc_vec(psc_vec), .psc_sel(psc_sel), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .wake_req(wake_req), .wake_status(wake_status)
  );

  function automatic logic [2:0] f_events(logic [CNT_W-1:0] c, logic [CNT_W-1:0] a,
                                          logic pbit, logic [CNT_W-1:0] pc, logic pb);
    logic [2:0] e;
    e[0] = (pc == '1) && (c == '0);
    e[1] = (c == a);
    e[2] = pbit && !pb;
    return e;
  endfunction

  function automatic logic [2:0] f_clear(logic we, logic wa, logic [2:0] wd);
    return (we && wa) ? wd : 3'b000;
  endfunction

  task automatic check(string tag, logic [2:0] st_exp, logic wk_exp);
    checks++;
    if (wake_status !== st_exp || wake_req !== wk_exp) begin
      failures++;
      $display("FAIL %s status=%b wake=%b expected status=%b wake=%b",
               tag, wake_status, wake_req, st_exp, wk_exp);
    end
  endtask

  task automatic step(string tag, logic [CNT_W-1:0] c, logic [PSC_W-1:0] p,
                      logic [SEL_W-1:0] s, logic we, logic wa, logic [2:0] wd);
    logic [2:0] e;
    @(negedge clk);
    cnt_val = c; psc_vec = p; psc_sel = s;
    wr_en = we; wr_addr = wa; wr_data = wd;
    e = f_events(c, alarm_val, p[s], m_prev_cnt, m_prev_bit);
    m_st = (m_st & ~f_clear(we, wa, wd)) | e;
    if (we && !wa) m_en = wd;
    m_prev_cnt = c;
    m_prev_bit = p[s];
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    check(tag, m_st, |(m_st & m_en));
  endtask

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [CNT_W-1:0] c;
    rst_n = 1'b0; cnt_val = '0; alarm_val = 32'h0000_1234; psc_vec = '0;
    psc_sel = '0; wr_en = 1'b0; wr_addr = 1'b0; wr_data = 3'b000;
    m_st = '0; m_en = '0; m_prev_cnt = '0; m_prev_bit = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R7 reset", 3'b000, 1'b0);

    // R8: event while disabled, then enable
    step("R2 alarm disabled", 32'h1234, '0, '0, 1'b0, 1'b0, 3'b000);
    step("R4 held disabled", 32'h10, '0, '0, 1'b0, 1'b0, 3'b000);
    step("R8 enable later", 32'h11, '0, '0, 1'b1, 1'b0, 3'b111);
    step("R5 clear alarm", 32'h12, '0, '0, 1'b1, 1'b1, 3'b010);
    // R1 overflow
    step("R1 all ones", '1, '0, '0, 1'b0, 1'b0, 3'b000);
    step("R1 wrap", '0, '0, '0, 1'b0, 1'b0, 3'b000);
    step("R5 zero write", 32'h3, '0, '0, 1'b1, 1'b1, 3'b000);
    step("R4 sticky", 32'h4, '0, '0, 1'b0, 1'b0, 3'b000);
    step("R1 all ones again", '1, '0, '0, 1'b1, 1'b1, 3'b001);
    step("R5 event wins", '0, '0, '0, 1'b1, 1'b1, 3'b001);
    step("R5 clear ovf", 32'h5, '0, '0, 1'b1, 1'b1, 3'b001);
    // R3 prescaler edge on bit 5
    step("R3 low", 32'h6, 16'h0000, 4'd5, 1'b0, 1'b0, 3'b000);
    step("R3 rise", 32'h7, 16'h0020, 4'd5, 1'b0, 1'b0, 3'b000);
    step("R3 high no edge", 32'h8, 16'h0020, 4'd5, 1'b1, 1'b1, 3'b100);
    step("R3 other bit", 32'h9, 16'h0001, 4'd5, 1'b0, 1'b0, 3'b000);
    step("R6 disable all", 32'h9, 16'h0001, 4'd5, 1'b1, 1'b0, 3'b000);
    step("R1 ovf disabled", '1, '0, 4'd5, 1'b0, 1'b0, 3'b000);
    step("R6 status no wake", '0, '0, 4'd5, 1'b0, 1'b0, 3'b000);
    step("R6 enable ovf", 32'h2, '0, 4'd5, 1'b1, 1'b0, 3'b001);

    void'($urandom(32'd1357));
    for (int i = 0; i < 2000; i++) begin
      case ($urandom % 4)
        0: c = '1;
        1: c = '0;
        2: c = alarm_val;
        default: c = CNT_W'($urandom);
      endcase
      step("random", c, PSC_W'($urandom), SEL_W'($urandom),
           ($urandom % 3) == 0, 1'($urandom), 3'($urandom));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule